// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block turns individual power domains of a chip on and off in hardware, one request at a time. A request names a domain by index and asks for it to be on or off. The sequencer then changes that domain's clock-enable, isolation, reset and power-down controls in a fixed order. It pauses for a settle time after each clock, isolation or reset step. It also waits for the power switch to acknowledge the change of power state, and gives up if the acknowledge does not arrive in time.

Every domain owns the same bit position in all four control vectors and in the acknowledge vector. The acknowledge arrives asynchronously and passes through a two-flop synchroniser before the sequencer compares it. A busy flag covers the whole sequence. Each request ends with a one-cycle `done` or `err` pulse, and the control vectors themselves show the state of every domain.

Top module: `pwrdom_seq`

## Requirements
- R1: After reset every domain has `clkEn`=1, `rstRel`=1 (reset released), `isoEn`=0 and `pwrDn`=0; `busy`, `done` and `err` are 0.
- R2: A power-off request changes the addressed domain in this order: `clkEn` cleared, `isoEn` set, `rstRel` cleared, `pwrDn` set. At least SETTLE_CYC+1 cycles separate a clock, isolation or reset change from the next change.
- R3: After `pwrDn` is set, power-off ends with `done` once the synchronised acknowledge bit of the domain reads 1. If it has not read 1 after OFF_POLL_LIMIT cycles of waiting, the request ends with `err`, and no further control change follows.
- R4: A power-on request clears `pwrDn`, waits for the synchronised acknowledge to read 0, then sets `rstRel`, clears `isoEn`, and sets `clkEn`. Each of the last three changes is followed by at least SETTLE_CYC cycles, and then `done` pulses.
- R5: If the acknowledge has not read 0 after ON_POLL_LIMIT cycles of waiting during power-on, the request ends with `err` and reset, isolation and clock controls stay unchanged.
- R6: In any cycle, control bits change in at most one domain, and only in the addressed one.
- R7: `busy` is high from the cycle after an accepted request until the cycle in which `done` or `err` pulses, where it is low. A request presented while `busy` is high is ignored.
- R8: A power-on request for a domain whose `clkEn` is 1, or a power-off request for a domain whose `pwrDn` is 1, pulses `done` in the next cycle with no control change, and `busy` stays low.
- R9: A request whose index is NUM_DOM or larger pulses `err` in the next cycle with no control change, and `busy` stays low.
- R10: `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is low |
| reqIdx | input | IDX_W | Domain index of the request |
| reqOn | input | 1 | 1 = power on, 0 = power off |
| ackAsync | input | NUM_DOM | Per-domain acknowledge from the power switches, asynchronous, 1 = powered down |
| clkEn | output | NUM_DOM | Per-domain clock enable |
| rstRel | output | NUM_DOM | Per-domain reset release (0 = reset asserted) |
| isoEn | output | NUM_DOM | Per-domain isolation enable |
| pwrDn | output | NUM_DOM | Per-domain power-down request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: request completed |
| err | output | 1 | One-cycle pulse: bad index or acknowledge timeout |

## Verification
The states hardest to reach from the ports are the partial ones left behind by a timeout. An example is a domain with power-down cleared but clock, isolation and reset still in the off position, which the next request must finish while skipping the steps already done. The bench models the power switch as a delayed copy of `pwrDn` and can pin a domain's acknowledge at a stale value. Directed stuck cases and random requests with random stuck choices drive the sequencer into these partial states and then issue follow-up requests against them. The bench also presents a request while a sequence is running, so that refusing requests is exercised.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_SETTLE,
    ST_POLL
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic clkClr;
    logic clkSet;
    logic isoSet;
    logic isoClr;
    logic rstAssert;
    logic rstRelease;
    logic pwrSet;
    logic pwrClr;
    logic ldSettle;
    logic decSettle;
    logic clrPoll;
    logic incPoll;
  } dpStrobe_t;

endpackage

// File: rtl/pds_datapath.sv
module pds_datapath
  import pds_pkg::*;
#(
  parameter int NUM_DOM        = 7,
  parameter int IDX_W          = 3,
  parameter int SETTLE_CYC     = 625,
  parameter int OFF_POLL_LIMIT = 1000,
  parameter int ON_POLL_LIMIT  = 10000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic               curOn,
  input  logic [NUM_DOM-1:0] ackAsync,
  output logic [NUM_DOM-1:0] clkEnQ,
  output logic [NUM_DOM-1:0] rstRelQ,
  output logic [NUM_DOM-1:0] isoEnQ,
  output logic [NUM_DOM-1:0] pwrDnQ,
  output logic               ackNow,
  output logic               settleZero,
  output logic               pollLast,
  output logic               reqClkEn,
  output logic               reqPwrDn
);

  localparam int POLL_MAX = (OFF_POLL_LIMIT > ON_POLL_LIMIT) ? OFF_POLL_LIMIT : ON_POLL_LIMIT;
  localparam int MAX_CNT  = (SETTLE_CYC > POLL_MAX) ? SETTLE_CYC : POLL_MAX;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LAST    = CNT_W'(OFF_POLL_LIMIT - 1);
  localparam logic [CNT_W-1:0] ON_LAST     = CNT_W'(ON_POLL_LIMIT - 1);

  logic [IDX_W-1:0]   curIdx;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_DOM-1:0] ackMeta;
  logic [NUM_DOM-1:0] ackSyncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curIdx <= '0;
    else if (stb.capture) curIdx <= reqIdx;
  end

  // two-flop synchroniser on the switch acknowledges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackMeta  <= '0;
      ackSyncQ <= '0;
    end else begin
      ackMeta  <= ackAsync;
      ackSyncQ <= ackMeta;
    end
  end

  // one counter serves both the settle delay and the acknowledge wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (stb.ldSettle)  cnt <= SETTLE_LOAD;
    else if (stb.clrPoll)   cnt <= '0;
    else if (stb.decSettle) cnt <= cnt - 1'b1;
    else if (stb.incPoll)   cnt <= cnt + 1'b1;
  end

  assign settleZero = (cnt == '0);
  assign pollLast   = (cnt == (curOn ? ON_LAST : OFF_LAST));

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    logic sel;
    logic clkB, rstB, isoB, pwrB;
    assign sel = (curIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkB <= 1'b1;
        rstB <= 1'b1;
        isoB <= 1'b0;
        pwrB <= 1'b0;
      end else if (sel) begin
        if (stb.clkClr)          clkB <= 1'b0;
        else if (stb.clkSet)     clkB <= 1'b1;
        if (stb.isoSet)          isoB <= 1'b1;
        else if (stb.isoClr)     isoB <= 1'b0;
        if (stb.rstAssert)       rstB <= 1'b0;
        else if (stb.rstRelease) rstB <= 1'b1;
        if (stb.pwrSet)          pwrB <= 1'b1;
        else if (stb.pwrClr)     pwrB <= 1'b0;
      end
    end

    assign clkEnQ[g]  = clkB;
    assign rstRelQ[g] = rstB;
    assign isoEnQ[g]  = isoB;
    assign pwrDnQ[g]  = pwrB;
  end

  always_comb begin
    ackNow   = 1'b0;
    reqClkEn = 1'b0;
    reqPwrDn = 1'b0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (curIdx == IDX_W'(i)) ackNow = ackSyncQ[i];
      if (reqIdx == IDX_W'(i)) begin
        reqClkEn = clkEnQ[i];
        reqPwrDn = pwrDnQ[i];
      end
    end
  end

  // the addressed domain index may not move while a sequence runs
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(curIdx));

endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqOn,
  input  logic      reqIdxValid,
  input  logic      reqClkEn,
  input  logic      reqPwrDn,
  input  logic      ackNow,
  input  logic      settleZero,
  input  logic      pollLast,
  output dpStrobe_t stb,
  output logic      curOn,
  output logic      busy,
  output logic      done,
  output logic      err
);

  seqState_t state, nState;
  logic [1:0] step, nStep;
  logic dirOn, nDir;
  logic doneQ, errQ, nDone, nErr;
  logic isPwrStep;

  assign isPwrStep = dirOn ? (step == 2'd0) : (step == 2'd3);

  always_comb begin
    stb    = '0;
    nState = state;
    nStep  = step;
    nDir   = dirOn;
    nDone  = 1'b0;
    nErr   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqIdxValid) nErr = 1'b1;
          else if (reqOn ? reqClkEn : reqPwrDn) nDone = 1'b1;
          else begin
            stb.capture = 1'b1;
            nDir   = reqOn;
            nStep  = 2'd0;
            nState = ST_ACT;
          end
        end
      end
      ST_ACT: begin
        if (dirOn) begin
          unique case (step)
            2'd0: stb.pwrClr     = 1'b1;
            2'd1: stb.rstRelease = 1'b1;
            2'd2: stb.isoClr     = 1'b1;
            default: stb.clkSet  = 1'b1;
          endcase
        end else begin
          unique case (step)
            2'd0: stb.clkClr    = 1'b1;
            2'd1: stb.isoSet    = 1'b1;
            2'd2: stb.rstAssert = 1'b1;
            default: stb.pwrSet = 1'b1;
          endcase
        end
        if (isPwrStep) begin
          stb.clrPoll = 1'b1;
          nState = ST_POLL;
        end else begin
          stb.ldSettle = 1'b1;
          nState = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settleZero) begin
          if (dirOn && step == 2'd3) begin
            nDone  = 1'b1;
            nState = ST_IDLE;
          end else begin
            nStep  = step + 2'd1;
            nState = ST_ACT;
          end
        end else begin
          stb.decSettle = 1'b1;
        end
      end
      ST_POLL: begin
        if (ackNow != dirOn) begin
          if (!dirOn) begin
            nDone  = 1'b1;
            nState = ST_IDLE;
          end else begin
            nStep  = step + 2'd1;
            nState = ST_ACT;
          end
        end else if (pollLast) begin
          nErr   = 1'b1;
          nState = ST_IDLE;
        end else begin
          stb.incPoll = 1'b1;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= 2'd0;
      dirOn <= 1'b1;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      state <= nState;
      step  <= nStep;
      dirOn <= nDir;
      doneQ <= nDone;
      errQ  <= nErr;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = doneQ;
  assign err   = errQ;
  assign curOn = dirOn;

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> !busy);

  p_refuse_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |-> !stb.capture);

endmodule

// File: rtl/pwrdom_seq.sv
module pwrdom_seq
  import pds_pkg::*;
#(
  parameter int NUM_DOM        = 7,
  parameter int SETTLE_CYC     = 625,
  parameter int OFF_POLL_LIMIT = 1000,
  parameter int ON_POLL_LIMIT  = 10000,
  localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM + 1) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic               reqOn,
  input  logic [NUM_DOM-1:0] ackAsync,
  output logic [NUM_DOM-1:0] clkEn,
  output logic [NUM_DOM-1:0] rstRel,
  output logic [NUM_DOM-1:0] isoEn,
  output logic [NUM_DOM-1:0] pwrDn,
  output logic               busy,
  output logic               done,
  output logic               err
);

  dpStrobe_t stb;
  logic curOn, ackNow, settleZero, pollLast, reqClkEn, reqPwrDn, reqIdxValid;

  assign reqIdxValid = (32'(reqIdx) < NUM_DOM);

  pds_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOn      (reqOn),
    .reqIdxValid(reqIdxValid),
    .reqClkEn   (reqClkEn),
    .reqPwrDn   (reqPwrDn),
    .ackNow     (ackNow),
    .settleZero (settleZero),
    .pollLast   (pollLast),
    .stb        (stb),
    .curOn      (curOn),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  pds_datapath #(
    .NUM_DOM       (NUM_DOM),
    .IDX_W         (IDX_W),
    .SETTLE_CYC    (SETTLE_CYC),
    .OFF_POLL_LIMIT(OFF_POLL_LIMIT),
    .ON_POLL_LIMIT (ON_POLL_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqIdx    (reqIdx),
    .curOn     (curOn),
    .ackAsync  (ackAsync),
    .clkEnQ    (clkEn),
    .rstRelQ   (rstRel),
    .isoEnQ    (isoEn),
    .pwrDnQ    (pwrDn),
    .ackNow    (ackNow),
    .settleZero(settleZero),
    .pollLast  (pollLast),
    .reqClkEn  (reqClkEn),
    .reqPwrDn  (reqPwrDn)
  );

  p_one_domain_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones((clkEn ^ $past(clkEn)) | (rstRel ^ $past(rstRel)) |
               (isoEn ^ $past(isoEn)) | (pwrDn ^ $past(pwrDn))) <= 1);

  // a domain only loses power once clock is off, isolation is on and reset is held
  p_off_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrDn & ~$past(pwrDn)) & ~(isoEn & ~rstRel & ~clkEn)) == '0);

  // a clock only returns with power up, reset released and isolation off
  p_on_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((clkEn & ~$past(clkEn)) & ~(~isoEn & rstRel & ~pwrDn)) == '0);

  // isolation only drops on a powered domain that is out of reset
  p_iso_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((~isoEn & $past(isoEn)) & ~(rstRel & ~pwrDn)) == '0);

endmodule

// File: tb/tb_pwrdom_seq.sv
module tb_pwrdom_seq;

  localparam int NUM    = 7;
  localparam int SETTLE = 4;
  localparam int OFFLIM = 40;
  localparam int ONLIM  = 80;
  localparam int IW     = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [IW-1:0] reqIdx = '0;
  logic reqOn = 1'b0;
  logic [NUM-1:0] ackAsync;
  logic [NUM-1:0] clkEn, rstRel, isoEn, pwrDn;
  logic busy, done, err;

  logic [NUM-1:0] ackP0, ackP1, ackP2;
  logic [NUM-1:0] stuckMask = '0, stuckVal = '0;
  logic [NUM-1:0] mClk = '1, mRst = '1, mIso = '0, mPwr = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwrdom_seq #(
    .NUM_DOM(NUM), .SETTLE_CYC(SETTLE), .OFF_POLL_LIMIT(OFFLIM), .ON_POLL_LIMIT(ONLIM)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqIdx), .reqOn(reqOn),
    .ackAsync(ackAsync), .clkEn(clkEn), .rstRel(rstRel), .isoEn(isoEn), .pwrDn(pwrDn),
    .busy(busy), .done(done), .err(err)
  );

  // power switch model: acknowledge trails power-down by three cycles unless pinned
  always_ff @(posedge clk) begin
    ackP0 <= pwrDn;
    ackP1 <= ackP0;
    ackP2 <= ackP1;
  end
  assign ackAsync = (stuckMask & stuckVal) | (~stuckMask & ackP2);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected event codes for the addressed domain, four bits each, count on top
  // 1 clk off, 2 iso on, 3 reset asserted, 4 power down, 5 power up, 6 reset released, 7 iso off, 8 clk on
  function automatic logic [19:0] expSeq(input logic on, input logic stuck,
                                         input logic c, input logic r, input logic i, input logic p);
    logic [15:0] codes = '0;
    int n = 0;
    if (!on) begin
      if (c)  begin codes[n*4 +: 4] = 4'd1; n++; end
      if (!i) begin codes[n*4 +: 4] = 4'd2; n++; end
      if (r)  begin codes[n*4 +: 4] = 4'd3; n++; end
      if (!p) begin codes[n*4 +: 4] = 4'd4; n++; end
    end else begin
      if (p) begin codes[n*4 +: 4] = 4'd5; n++; end
      if (!stuck) begin
        if (!r) begin codes[n*4 +: 4] = 4'd6; n++; end
        if (i)  begin codes[n*4 +: 4] = 4'd7; n++; end
        if (!c) begin codes[n*4 +: 4] = 4'd8; n++; end
      end
    end
    return {4'(n), codes};
  endfunction

  task automatic runReq(input int idx, input logic on, input logic stuck);
    logic valid, already, expErr, expImm;
    logic [19:0] es;
    int nev, expN, cyc, tEnd, tPwr;
    int evCode[8];
    int evTime[8];
    int other;
    logic [NUM-1:0] pC, pR, pI, pP, mask;
    bit ended, busyBad;

    valid   = (idx < NUM);
    already = valid && (on ? mClk[idx] : mPwr[idx]);
    expImm  = !valid || already;
    expErr  = !valid || (!already && stuck);
    es      = valid ? expSeq(on, stuck, mClk[idx], mRst[idx], mIso[idx], mPwr[idx]) : '0;
    expN    = expImm ? 0 : int'(es[19:16]);
    other   = valid ? ((idx + 1) % NUM) : 0;
    mask    = valid ? (NUM'(1) << idx) : '0;

    if (valid && stuck) begin
      stuckMask[idx] = 1'b1;
      stuckVal[idx]  = on;
    end
    repeat (2) @(negedge clk);
    pC = clkEn; pR = rstRel; pI = isoEn; pP = pwrDn;
    reqIdx = IW'(idx); reqOn = on; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    nev = 0; cyc = 1; ended = 0; busyBad = 0; tEnd = 0; tPwr = -1;
    while (!ended && cyc < 3000) begin
      // R6: no other domain moves
      check((((clkEn ^ pC) | (rstRel ^ pR) | (isoEn ^ pI) | (pwrDn ^ pP)) & ~mask) == '0,
            "R6", "other domain changed", 1, 0);
      if (valid) begin
        if (pC[idx] && !clkEn[idx])  begin evCode[nev] = 1; evTime[nev] = cyc; nev++; end
        if (!pI[idx] && isoEn[idx])  begin evCode[nev] = 2; evTime[nev] = cyc; nev++; end
        if (pR[idx] && !rstRel[idx]) begin evCode[nev] = 3; evTime[nev] = cyc; nev++; end
        if (!pP[idx] && pwrDn[idx])  begin evCode[nev] = 4; evTime[nev] = cyc; nev++; tPwr = cyc; end
        if (pP[idx] && !pwrDn[idx])  begin evCode[nev] = 5; evTime[nev] = cyc; nev++; tPwr = cyc; end
        if (!pR[idx] && rstRel[idx]) begin evCode[nev] = 6; evTime[nev] = cyc; nev++; end
        if (pI[idx] && !isoEn[idx])  begin evCode[nev] = 7; evTime[nev] = cyc; nev++; end
        if (!pC[idx] && clkEn[idx])  begin evCode[nev] = 8; evTime[nev] = cyc; nev++; end
      end
      pC = clkEn; pR = rstRel; pI = isoEn; pP = pwrDn;
      if (done || err) begin
        ended = 1; tEnd = cyc;
        check(!busy, "R7", "busy at end pulse", int'(busy), 0);
        check(err == expErr, expErr ? (valid ? (on ? "R5" : "R3") : "R9") : (expImm ? "R8" : (on ? "R4" : "R3")),
              "err at end", int'(err), int'(expErr));
      end else if (!busy) busyBad = 1;
      if (cyc == 3 && busy) begin
        // R7: a request during a sequence is refused
        reqIdx = IW'(other); reqOn = !clkEn[other]; reqValid = 1'b1;
      end
      if (cyc == 4) reqValid = 1'b0;
      if (!ended) begin
        @(negedge clk);
        cyc++;
      end
    end
    reqValid = 1'b0;
    check(ended, "R7", "request never ended", cyc, 0);
    check(!busyBad, "R7", "busy dropped early", 1, 0);
    if (expImm) check(tEnd == 1, valid ? "R8" : "R9", "immediate end cycle", tEnd, 1);
    check(nev == expN, on ? "R4" : "R2", "event count", nev, expN);
    for (int k = 0; k < nev && k < expN; k++)
      check(evCode[k] == int'(es[k*4 +: 4]), on ? "R4" : "R2", "event order", evCode[k], int'(es[k*4 +: 4]));
    for (int k = 1; k < nev; k++)
      if (evCode[k-1] inside {1, 2, 3, 6, 7})
        check(evTime[k] - evTime[k-1] >= SETTLE + 1, on ? "R4" : "R2", "settle gap", evTime[k] - evTime[k-1], SETTLE + 1);
    if (nev > 0 && evCode[nev-1] == 8 && done)
      check(tEnd - evTime[nev-1] >= SETTLE, "R4", "settle before done", tEnd - evTime[nev-1], SETTLE);
    if (!expImm && expErr && tPwr >= 0) begin
      if (on) check(tEnd - tPwr >= ONLIM && tEnd - tPwr <= ONLIM + 1, "R5", "on timeout length", tEnd - tPwr, ONLIM);
      else    check(tEnd - tPwr >= OFFLIM && tEnd - tPwr <= OFFLIM + 1, "R3", "off timeout length", tEnd - tPwr, OFFLIM);
    end
    @(negedge clk);
    check(!done && !err, "R10", "pulse longer than one cycle", int'(done) + int'(err), 0);
    // R3/R5: nothing moves after the end of a request
    check(clkEn == pC && rstRel == pR && isoEn == pI && pwrDn == pP, expErr ? "R5" : "R3",
          "change after end", 1, 0);
    if (valid && !already) begin
      if (!on) begin
        mClk[idx] = 0; mIso[idx] = 1; mRst[idx] = 0; mPwr[idx] = 1;
      end else begin
        mPwr[idx] = 0;
        if (!stuck) begin mRst[idx] = 1; mIso[idx] = 0; mClk[idx] = 1; end
      end
    end
    if (valid) stuckMask[idx] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check(clkEn == '1 && rstRel == '1, "R1", "clock/reset after reset", int'(clkEn & rstRel), (1 << NUM) - 1);
    check(isoEn == '0 && pwrDn == '0, "R1", "iso/power after reset", int'(isoEn | pwrDn), 0);
    check(!busy && !done && !err, "R1", "status after reset", int'({busy, done, err}), 0);

    runReq(7, 1'b0, 1'b0);   // R9 bad index
    runReq(2, 1'b1, 1'b0);   // R8 already on
    runReq(2, 1'b0, 1'b0);   // R2 R3 normal off
    runReq(2, 1'b0, 1'b0);   // R8 already off
    runReq(2, 1'b1, 1'b0);   // R4 normal on
    runReq(0, 1'b0, 1'b0);
    runReq(6, 1'b0, 1'b0);
    runReq(6, 1'b1, 1'b0);
    runReq(4, 1'b0, 1'b1);   // R3 off timeout
    runReq(4, 1'b1, 1'b1);   // R5 on timeout
    runReq(4, 1'b0, 1'b0);   // off from partial state
    runReq(4, 1'b1, 1'b1);
    runReq(4, 1'b1, 1'b0);   // on from partial state

    for (int n = 0; n < 40; n++)
      runReq(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule